// File: doc/BRIEF.md
# Split-Word Seconds Counter with Read Freeze

This block keeps a 48-bit count of elapsed seconds. It advances from a tick-enable input that pulses at the slow timebase rate, 32768 per second by default. A 32-bit register bus reaches the count as two words: a low word with bits 31:0 and a high word with bits 47:32. Software sets the time by writing the low word and then the high word. Both writes restart the sub-second phase, so the new value starts at a whole-second boundary.

A 32-bit bus cannot read a 48-bit counter in one access. A freeze mode closes that gap. When the mode field holds the freeze code, a low-word read captures the high word at the same instant, and the bus shows the captured copy until software reads the high word. The counter itself does not stop while the copy is held.

A signed trim register corrects the rate in whole ticks per hour. A positive trim drops that many ticks per hour and slows the clock. A negative trim counts that many ticks twice and speeds it up. The corrections are spread evenly across the hour.

Top module: `split_sec_counter`

## Requirements
- R1: After reset, every register reads 0: low word, high word, trim and control.
- R2: With a trim of 0, the seconds count rises by exactly one for every TICKS_PER_SEC cycles that have tick_en high. Cycles with tick_en low change nothing.
- R3: A write to 0x08 loads seconds bits 31:0. A write to 0x0C loads bits 47:32 from wdata bits 15:0 and ignores wdata bits 31:16. A high-word read returns 0 in bits 31:16. Either write restarts the sub-second phase at zero.
- R4: A carry out of the low word increments the high word. The count wraps from 2^48-1 to 0.
- R5: The control register at 0x50 holds a mode field in bits 25:24. When that field is 2, a read of 0x08 captures the high word. Reads of 0x0C then return the captured value, and the first such read releases the capture.
- R6: While the high word is captured, the counter keeps advancing. After the release, a high-word read shows the live value.
- R7: Mode values other than 2 capture nothing. Control reads return only bits 25:24, and every other bit reads 0.
- R8: The trim register at 0x10 is a 32-bit two's-complement value that reads back exactly as written.
- R9: Let N be the trim magnitude and let TICKS_PER_SEC*SECS_PER_HOUR ticks make one hour. Over each such window, N tick-enables are dropped when the trim is positive, and N are counted twice when it is negative. Each correction falls on the tick where an accumulator that adds N per tick reaches the window length.
- R10: A trim magnitude of TICKS_PER_SEC*SECS_PER_HOUR or more acts as that window length minus one.
- R11: Reads of addresses that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One timebase tick per cycle while high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; captures take effect at the clock edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address while bus_rd is high, otherwise 0 |

## Verification
Some properties are checked on every cycle. The sub-second phase and the trim accumulator must stay below their limits. A low-word read in freeze mode must capture the high word as it stood at that read, and a high-word read must always drop the capture. The high half of a high-word read must be zero, high-word loads must take effect on the next cycle, and the count must wrap to zero from all ones.

Other behaviour only the directed scenarios can show. These cover the exact number of seconds produced by a given tick count under positive, negative and clamped trims, and the coherent pair returned across a carry while the counter keeps running. They also show that non-freeze modes return the live high word.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_SEC_LO = 8'h08;
    localparam logic [ADDR_W-1:0] ADDR_SEC_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] ADDR_TRIM   = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h50;
    localparam int               MODE_LSB    = 24;
    localparam logic [1:0]       MODE_FREEZE = 2'd2;
    // tick weight: 0 dropped, 1 normal, 2 counted twice
    localparam logic [1:0]       STEP_DROP   = 2'd0;
    localparam logic [1:0]       STEP_ONE    = 2'd1;
    localparam logic [1:0]       STEP_TWO    = 2'd2;
endpackage

// File: rtl/ssc_rate_trim.sv
module ssc_rate_trim #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_HOUR = 3600,
    parameter int CAL_W         = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CAL_W-1:0] trim,
    output logic [1:0]       step
);
    import ssc_pkg::*;

    localparam int unsigned TPH   = TICKS_PER_SEC * SECS_PER_HOUR;
    localparam int          ACC_W = $clog2(TPH);
    localparam int          SW    = CAL_W + 1;
    localparam logic [SW-1:0] TPH_W   = SW'(TPH);
    localparam logic [SW-1:0] MAG_MAX = SW'(TPH - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } trim_st_t;

    trim_st_t    st_d, st_q;
    logic [SW-1:0] mag_raw, mag, sum;

    always_comb begin
        mag_raw = trim[CAL_W-1] ? (SW'(0) - {trim[CAL_W-1], trim}) : {1'b0, trim};
        mag     = (mag_raw > MAG_MAX) ? MAG_MAX : mag_raw;
        sum     = SW'(st_q.acc) + mag;
        st_d    = st_q;
        step    = STEP_DROP;
        if (tick_en) begin
            if (sum >= TPH_W) begin
                st_d.acc = ACC_W'(sum - TPH_W);
                step     = trim[CAL_W-1] ? STEP_TWO : STEP_DROP;
            end else begin
                st_d.acc = ACC_W'(sum);
                step     = STEP_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SW'(st_q.acc) < TPH_W);

    // R9
    step_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step != 2'd3);
endmodule

// File: rtl/ssc_prescaler.sv
module ssc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] step,
    input  logic       restart,
    output logic       sec_pulse
);
    localparam int PRE_W = $clog2(TICKS_PER_SEC);
    localparam int SUM_W = PRE_W + 2;
    localparam logic [SUM_W-1:0] TPS_W = SUM_W'(TICKS_PER_SEC);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_st_t;

    pre_st_t        st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum       = SUM_W'(st_q.phase) + SUM_W'(step);
        st_d      = st_q;
        sec_pulse = 1'b0;
        if (restart) begin
            st_d.phase = '0;
        end else if (sum >= TPS_W) begin
            st_d.phase = PRE_W'(sum - TPS_W);
            sec_pulse  = 1'b1;
        end else begin
            st_d.phase = PRE_W'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(st_q.phase) < TPS_W);

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.phase == '0);
endmodule

// File: rtl/split_sec_counter.sv
module split_sec_counter #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_HOUR = 3600,
    parameter int SEC_W         = 48,
    parameter int DATA_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    import ssc_pkg::*;

    localparam int HI_W = SEC_W - DATA_W;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [HI_W-1:0]   hi_snap;
        logic              frozen;
        logic [1:0]        mode;
        logic [DATA_W-1:0] trim;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    wr_lo, wr_hi, wr_trim, wr_ctrl, rd_lo, rd_hi;
    logic [1:0] step;
    logic    sec_pulse;
    logic [HI_W-1:0] hi_view;

    assign wr_lo   = bus_wr && (bus_addr == ADDR_SEC_LO);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_SEC_HI);
    assign wr_trim = bus_wr && (bus_addr == ADDR_TRIM);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign rd_lo   = bus_rd && (bus_addr == ADDR_SEC_LO);
    assign rd_hi   = bus_rd && (bus_addr == ADDR_SEC_HI);

    ssc_rate_trim #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SECS_PER_HOUR (SECS_PER_HOUR),
        .CAL_W         (DATA_W)
    ) u_trim (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .trim    (st_q.trim),
        .step    (step)
    );

    ssc_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .restart   (wr_lo || wr_hi),
        .sec_pulse (sec_pulse)
    );

    always_comb begin
        st_d = st_q;
        // time load beats the per-second increment
        if (wr_lo) begin
            st_d.sec[DATA_W-1:0] = bus_wdata;
        end else if (wr_hi) begin
            st_d.sec[SEC_W-1:DATA_W] = bus_wdata[HI_W-1:0];
        end else if (sec_pulse) begin
            st_d.sec = st_q.sec + SEC_W'(1);
        end
        if (wr_trim) st_d.trim = bus_wdata;
        if (wr_ctrl) st_d.mode = bus_wdata[MODE_LSB+1:MODE_LSB];
        // capture handling
        if ((st_q.mode != MODE_FREEZE) || rd_hi || wr_hi) st_d.frozen = 1'b0;
        if (rd_lo && (st_q.mode == MODE_FREEZE)) begin
            st_d.frozen  = 1'b1;
            st_d.hi_snap = st_q.sec[SEC_W-1:DATA_W];
        end
    end

    always_comb begin
        hi_view   = st_q.frozen ? st_q.hi_snap : st_q.sec[SEC_W-1:DATA_W];
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_SEC_LO: bus_rdata = st_q.sec[DATA_W-1:0];
                ADDR_SEC_HI: bus_rdata = {{(DATA_W-HI_W){1'b0}}, hi_view};
                ADDR_TRIM:   bus_rdata = st_q.trim;
                ADDR_CTRL:   bus_rdata[MODE_LSB +: 2] = st_q.mode;
                default:     bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.sec && sec_pulse) |=> st_q.sec == '0);

    // R5
    frz_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && st_q.mode == MODE_FREEZE)
            |=> (st_q.frozen && st_q.hi_snap == $past(st_q.sec[SEC_W-1:DATA_W])));

    // R5
    frz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> !st_q.frozen);

    // R7
    no_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_FREEZE) |=> !st_q.frozen);

    // R3
    hi_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |-> bus_rdata[DATA_W-1:HI_W] == '0);

    // R3
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> st_q.sec[SEC_W-1:DATA_W] == $past(bus_wdata[HI_W-1:0]));
endmodule

// File: tb/split_sec_counter_tb.sv
module split_sec_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;
    localparam int SPH        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    split_sec_counter #(
        .TICKS_PER_SEC (TPS),
        .SECS_PER_HOUR (SPH),
        .SEC_W         (48),
        .DATA_W        (32)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [7:0] a, logic [31:0] exp, string req);
        logic [31:0] got;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 got = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, got, exp);
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        rd_expect(8'h08, 32'h0, "R1 lo");
        rd_expect(8'h0C, 32'h0, "R1 hi");
        rd_expect(8'h10, 32'h0, "R1 trim");
        rd_expect(8'h50, 32'h0, "R1 ctrl");
    endtask

    task automatic t_count();
        do_reset();
        ticks(5 * TPS);
        rd_expect(8'h08, 32'd5, "R2 five seconds");
        repeat (10) @(negedge clk);
        rd_expect(8'h08, 32'd5, "R2 idle no count");
        ticks(TPS - 1);
        rd_expect(8'h08, 32'd5, "R2 before boundary");
        ticks(1);
        rd_expect(8'h08, 32'd6, "R2 at boundary");
    endtask

    task automatic t_load_carry_wrap();
        do_reset();
        ticks(2);
        wr(8'h08, 32'hFFFF_FFFE);
        wr(8'h0C, 32'hABCD_0012);
        rd_expect(8'h08, 32'hFFFF_FFFE, "R3 lo load");
        rd_expect(8'h0C, 32'h0000_0012, "R3 hi load reserved ignored");
        ticks(2 * TPS);
        rd_expect(8'h08, 32'h0, "R4 carry lo");
        rd_expect(8'h0C, 32'h13, "R4 carry hi");
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0000_FFFF);
        ticks(TPS - 1);
        rd_expect(8'h08, 32'hFFFF_FFFF, "R3 restart phase");
        ticks(1);
        rd_expect(8'h08, 32'h0, "R4 wrap lo");
        rd_expect(8'h0C, 32'h0, "R4 wrap hi");
    endtask

    task automatic t_freeze();
        do_reset();
        wr(8'h50, 32'h0200_0000);
        rd_expect(8'h50, 32'h0200_0000, "R5 ctrl readback");
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0000_0005);
        rd_expect(8'h08, 32'hFFFF_FFFF, "R5 lo read");
        ticks(TPS);
        rd_expect(8'h0C, 32'h5, "R5 frozen hi");
        rd_expect(8'h0C, 32'h6, "R6 released hi live");
        rd_expect(8'h08, 32'h0, "R6 counted while frozen");
    endtask

    task automatic t_no_freeze();
        do_reset();
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0000_0005);
        rd_expect(8'h08, 32'hFFFF_FFFF, "R7 lo read mode0");
        ticks(TPS);
        rd_expect(8'h0C, 32'h6, "R7 mode0 live hi");
        wr(8'h50, 32'hFFFF_FFFF);
        rd_expect(8'h50, 32'h0300_0000, "R7 ctrl only field");
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0000_0009);
        rd_expect(8'h08, 32'hFFFF_FFFF, "R7 lo read mode3");
        ticks(TPS);
        rd_expect(8'h0C, 32'hA, "R7 mode3 live hi");
    endtask

    task automatic t_unmapped();
        do_reset();
        wr(8'h10, 32'h1234_5678);
        rd_expect(8'h14, 32'h0, "R11 unmapped 0x14");
        rd_expect(8'h00, 32'h0, "R11 unmapped 0x00");
        rd_expect(8'h10, 32'h1234_5678, "R8 trim readback");
    endtask

    task automatic t_trim();
        do_reset();
        wr(8'h10, 32'd2);
        ticks(TPS * SPH);
        rd_expect(8'h08, 32'd1, "R9 positive drops");
        do_reset();
        wr(8'h10, 32'hFFFF_FFFE);
        rd_expect(8'h10, 32'hFFFF_FFFE, "R8 negative readback");
        ticks(TPS * SPH);
        rd_expect(8'h08, 32'd2, "R9 negative doubles");
        ticks(2);
        rd_expect(8'h08, 32'd3, "R9 spread next hour");
        do_reset();
        wr(8'h10, 32'hFFFF_FFFC);
        ticks(TPS * SPH);
        rd_expect(8'h08, 32'd3, "R9 negative four");
    endtask

    task automatic t_clamp();
        do_reset();
        wr(8'h10, 32'd1000);
        ticks(4 * TPS * SPH);
        rd_expect(8'h08, 32'd1, "R10 positive clamp");
        do_reset();
        wr(8'h10, 32'hFFFF_FC18);
        ticks(TPS * SPH);
        rd_expect(8'h08, 32'd3, "R10 negative clamp");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_count();
        t_load_carry_wrap();
        t_freeze();
        t_no_freeze();
        t_unmapped();
        t_trim();
        t_clamp();
        summary();
        $finish;
    end
endmodule